// File: doc/BRIEF.md
# Dot-Dash Bit-Store Display

This block holds a small bit store of 32 words, each 32 bits wide, and shows it continuously on a VGA monitor. Every bit appears as a mark in a 32 by 32 grid. A cleared bit gives a short dot and a set bit gives a longer dash, so a viewer reads each word as a row of marks. The grid is centred on a black screen.

The store is a dual-clock, dual-port RAM. A processor reads and writes it on its own clock, which has no fixed relation to the pixel clock. The display side reads the same array through a second, read-only port in the pixel domain. The two ports do not arbitrate against each other. Because the screen is redrawn from the live store on every frame, a processor write shows up on the screen without any copy step. A scan controller produces the line and frame counters and the two sync pulses. It also works out where each pixel falls in the grid. At the start of every line it fetches that line's word, which is well before the grid's first cell.

Top module: `dotdash_vga`

## Requirements
- R1: The processor port writes `cpuWdata` into word `cpuAddr` on a rising `cpuClk` edge when `cpuWe` is high. `cpuRdata` is registered and gives the word at `cpuAddr` as it stood before that edge, so a read during a write to the same word returns the old value.
- R2: `hSyncN` is low for exactly H_SYNC pixels of each line of H_VIS+H_FP+H_SYNC+H_BP pixels. The pulse starts H_VIS+H_FP pixels after the first visible pixel. The defaults are 640/16/96/48.
- R3: `vSyncN` is low for exactly V_SYNC whole lines of each frame of V_VIS+V_FP+V_SYNC+V_BP lines. The pulse starts at line V_VIS+V_FP. The defaults are 480/10/2/33.
- R4: `pixRgb` is zero at every pixel outside the visible area. It is also zero outside the grid, which is 32·CELL_W pixels wide and 32·BAND_H lines tall. The grid starts at column (H_VIS−32·CELL_W)/2 and line (V_VIS−32·BAND_H)/2.
- R5: Word w is drawn in band w counted from the top. Bit b of that word is drawn in cell column b counted from the left, so bit 0 is leftmost.
- R6: A bit of value 0 lights DOT_LEN pixels (default 4), starting at the left edge of its cell. The rest of the cell stays dark.
- R7: A bit of value 1 lights DASH_LEN pixels (default 12), starting at the left edge of its cell. The rest of the cell stays dark.
- R8: Marks appear only on MARK_H lines (default 2) of each band. These lines start at line (BAND_H−MARK_H)/2 within the band. All other lines of the band stay dark.
- R9: A lit pixel drives all 12 bits of `pixRgb` high, which gives white.
- R10: During reset, `hSyncN` and `vSyncN` are high and `pixRgb` is zero. The outputs have one pixel clock of latency: the first rising edge after reset drives the outputs for line 0, pixel 0.
- R11: The word for a line is read from the store at pixel 0 of that line. A processor write that completes before a line starts is therefore shown on that line, with no copy step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpuClk | input | 1 | Processor port clock |
| cpuWe | input | 1 | Write enable for the processor port |
| cpuAddr | input | 5 | Word address for the processor port |
| cpuWdata | input | 32 | Data to write |
| cpuRdata | output | 32 | Registered read data (old value when a write hits the same word) |
| pixClk | input | 1 | Pixel clock, 25 MHz for the default mode |
| rstN | input | 1 | Synchronous reset for the pixel domain, active low |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| pixRgb | output | 12 | Pixel colour, 4 bits for each of red, green and blue |

## Verification
The mark assertions assume that no word changes between the fetch at pixel 0 of a line and the end of that line. If it did, the latched word and the store would disagree. They also assume that the grid's left edge is at least one pixel from the start of the line, so the fetch always lands before the first cell. The bench keeps within this by writing only while reset is held and during the vertical blanking after the first frame. It runs a reduced timing mode through the parameters so that two whole frames fit in the run. Against a behavioural screen model, it checks both sync signals and every pixel, and it checks processor reads and a read during a write.

// File: rtl/dotdash_pkg.sv
`timescale 1ns/1ps
package dotdash_pkg;
  localparam int WORDS    = 32;
  localparam int BITS     = 32;
  localparam int ADDR_W   = 5;
  localparam int COL_W    = 5;
  localparam int OFF_W    = 5;   // cells up to 32 pixels wide
  localparam int CH_W     = 4;   // bits per colour channel
  localparam int RGB_W    = 3 * CH_W;

  // strobes from the scan controller to the store datapath
  typedef struct packed {
    logic              fetch;     // latch the line word this cycle
    logic [ADDR_W-1:0] fetchRow;  // word to latch
    logic              visible;   // inside the active picture
    logic              markWin;   // grid cell on a mark line
    logic [COL_W-1:0]  col;       // bit column under the beam
    logic [OFF_W-1:0]  offs;      // pixel offset inside the cell
  } scanStrb_t;
endpackage

// File: rtl/dd_scan_ctrl.sv
`timescale 1ns/1ps
module dd_scan_ctrl
  import dotdash_pkg::*;
#(
  parameter int H_VIS   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter int CELL_W  = 16,
  parameter int BAND_H  = 12,
  parameter int MARK_H  = 2
) (
  input  logic      pixClk,
  input  logic      rstN,
  output logic      hSyncN,
  output logic      vSyncN,
  output scanStrb_t strb
);
  localparam int H_TOT     = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT     = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HC_W      = $clog2(H_TOT);
  localparam int VC_W      = $clog2(V_TOT);
  localparam int BL_W      = (BAND_H > 1) ? $clog2(BAND_H) : 1;
  localparam int CELL_LG   = $clog2(CELL_W);
  localparam int GRID_W    = BITS * CELL_W;
  localparam int GRID_H    = WORDS * BAND_H;
  localparam int GRID_LEFT = (H_VIS - GRID_W) / 2;
  localparam int GRID_TOP  = (V_VIS - GRID_H) / 2;
  localparam int MARK_TOP  = (BAND_H - MARK_H) / 2;
  localparam int HS_BEG    = H_VIS + H_FP;
  localparam int HS_END    = HS_BEG + H_SYNC;
  localparam int VS_BEG    = V_VIS + V_FP;
  localparam int VS_END    = VS_BEG + V_SYNC;

  logic [HC_W-1:0]   hCnt;
  logic [VC_W-1:0]   vCnt;
  logic [BL_W-1:0]   bandLine;
  logic [ADDR_W-1:0] rowIdx;
  logic              lineEnd, frameEnd, nextIsTop, inGridH, inGridV, onMarkLine;
  int                xPos;

  always_comb begin
    lineEnd    = (int'(hCnt) == H_TOT - 1);
    frameEnd   = (int'(vCnt) == V_TOT - 1);
    nextIsTop  = frameEnd ? (GRID_TOP == 0) : (int'(vCnt) + 1 == GRID_TOP);
    xPos       = int'(hCnt) - GRID_LEFT;
    inGridH    = (xPos >= 0) && (xPos < GRID_W);
    inGridV    = (int'(vCnt) >= GRID_TOP) && (int'(vCnt) < GRID_TOP + GRID_H);
    onMarkLine = (int'(bandLine) >= MARK_TOP) && (int'(bandLine) < MARK_TOP + MARK_H);
  end

  always_ff @(posedge pixClk) begin
    if (!rstN) begin
      hCnt     <= '0;
      vCnt     <= '0;
      bandLine <= '0;
      rowIdx   <= '0;
      hSyncN   <= 1'b1;
      vSyncN   <= 1'b1;
    end else begin
      hSyncN <= !((int'(hCnt) >= HS_BEG) && (int'(hCnt) < HS_END));
      vSyncN <= !((int'(vCnt) >= VS_BEG) && (int'(vCnt) < VS_END));
      if (lineEnd) begin
        hCnt <= '0;
        vCnt <= frameEnd ? '0 : vCnt + 1'b1;
        if (nextIsTop) begin
          bandLine <= '0;
          rowIdx   <= '0;
        end else if (int'(bandLine) == BAND_H - 1) begin
          bandLine <= '0;
          rowIdx   <= rowIdx + 1'b1;
        end else begin
          bandLine <= bandLine + 1'b1;
        end
      end else begin
        hCnt <= hCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.fetch    = (hCnt == '0);
    strb.fetchRow = rowIdx;
    strb.visible  = (int'(hCnt) < H_VIS) && (int'(vCnt) < V_VIS);
    strb.markWin  = strb.visible && inGridH && inGridV && onMarkLine;
    strb.col      = COL_W'(xPos >>> CELL_LG);
    strb.offs     = OFF_W'(xPos & (CELL_W - 1));
  end

  AST_HCNT_BOUND: assert property (@(posedge pixClk) disable iff (!rstN)
    int'(hCnt) < H_TOT); // R2
  AST_HSYNC_EDGE: assert property (@(posedge pixClk) disable iff (!rstN)
    $fell(hSyncN) |-> (int'(hCnt) == HS_BEG + 1)); // R2
  AST_VSYNC_EDGE: assert property (@(posedge pixClk) disable iff (!rstN)
    !$stable(vSyncN) |-> (int'(hCnt) == 1)); // R3
  AST_FETCH_OFF_GRID: assert property (@(posedge pixClk) disable iff (!rstN)
    strb.fetch |-> !strb.markWin); // R11
endmodule

// File: rtl/dd_store_path.sv
`timescale 1ns/1ps
module dd_store_path
  import dotdash_pkg::*;
#(
  parameter int DOT_LEN  = 4,
  parameter int DASH_LEN = 12
) (
  input  logic              cpuClk,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [BITS-1:0]   cpuWdata,
  output logic [BITS-1:0]   cpuRdata,
  input  logic              pixClk,
  input  logic              rstN,
  input  scanStrb_t         strb,
  output logic [RGB_W-1:0]  pixRgb
);
  logic [BITS-1:0] store [WORDS];
  logic [BITS-1:0] rowWord;
  logic            bitVal, lit;

  // processor port: read returns the word as it was before this edge
  always_ff @(posedge cpuClk) begin
    if (cpuWe) store[cpuAddr] <= cpuWdata;
    cpuRdata <= store[cpuAddr];
  end

  // display port: read only, one word per line
  always_ff @(posedge pixClk) begin
    if (strb.fetch) rowWord <= store[strb.fetchRow];
  end

  always_comb begin
    bitVal = rowWord[strb.col];
    lit    = strb.markWin && (int'(strb.offs) < (bitVal ? DASH_LEN : DOT_LEN));
  end

  always_ff @(posedge pixClk) begin
    if (!rstN) pixRgb <= '0;
    else       pixRgb <= lit ? '1 : '0;
  end

  AST_DARK_BLANK: assert property (@(posedge pixClk) disable iff (!rstN)
    !$past(strb.visible) |-> (pixRgb == '0)); // R4
  AST_LIT_ON_MARK: assert property (@(posedge pixClk) disable iff (!rstN)
    (pixRgb != '0) |-> $past(strb.markWin)); // R8
  AST_MARK_LEN_CAP: assert property (@(posedge pixClk) disable iff (!rstN)
    (pixRgb != '0) |-> (int'($past(strb.offs)) < DASH_LEN)); // R7
  AST_FULL_WHITE: assert property (@(posedge pixClk) disable iff (!rstN)
    (pixRgb == '0) || (pixRgb == '1)); // R9
endmodule

// File: rtl/dotdash_vga.sv
`timescale 1ns/1ps
module dotdash_vga
  import dotdash_pkg::*;
#(
  parameter int H_VIS    = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_VIS    = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int CELL_W   = 16,
  parameter int BAND_H   = 12,
  parameter int MARK_H   = 2,
  parameter int DOT_LEN  = 4,
  parameter int DASH_LEN = 12
) (
  input  logic        cpuClk,
  input  logic        cpuWe,
  input  logic [4:0]  cpuAddr,
  input  logic [31:0] cpuWdata,
  output logic [31:0] cpuRdata,
  input  logic        pixClk,
  input  logic        rstN,
  output logic        hSyncN,
  output logic        vSyncN,
  output logic [11:0] pixRgb
);
  scanStrb_t strb;

  dd_scan_ctrl #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .CELL_W(CELL_W), .BAND_H(BAND_H), .MARK_H(MARK_H)
  ) u_ctrl (
    .pixClk(pixClk), .rstN(rstN),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .strb(strb)
  );

  dd_store_path #(
    .DOT_LEN(DOT_LEN), .DASH_LEN(DASH_LEN)
  ) u_path (
    .cpuClk(cpuClk), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .pixClk(pixClk), .rstN(rstN), .strb(strb), .pixRgb(pixRgb)
  );
endmodule

// File: tb/dotdash_vga_bench.sv
`timescale 1ns/1ps
module dotdash_vga_bench;
  // reduced mode so two whole frames fit in the run
  localparam int HV = 320, HF = 8, HS = 48, HB = 24;
  localparam int VV = 160, VF = 5, VS = 2, VB = 13;
  localparam int CW = 8, BH = 4, MH = 2, DOT = 2, DASH = 6;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int GW = 32 * CW, GH = 32 * BH;
  localparam int GL = (HV - GW) / 2, GT = (VV - GH) / 2;
  localparam int MT = (BH - MH) / 2;

  logic        cpuClk = 0, pixClk = 0, rstN = 0;
  logic        cpuWe = 0;
  logic [4:0]  cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        hSyncN, vSyncN;
  logic [11:0] pixRgb;

  int checks = 0, errors = 0;
  int hm = 0, vm = 0, frameNo = 0;
  logic [31:0] refMem [32];

  dotdash_vga #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .CELL_W(CW), .BAND_H(BH), .MARK_H(MH), .DOT_LEN(DOT), .DASH_LEN(DASH)
  ) u_dotdash_vga (
    .cpuClk(cpuClk), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .pixClk(pixClk), .rstN(rstN),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .pixRgb(pixRgb)
  );

  initial forever #2.5 pixClk = ~pixClk;   // 200 MHz
  initial forever #7   cpuClk = ~cpuClk;

  function automatic logic [31:0] patA(input int w);
    if (w == 0)  return 32'h0;
    if (w == 31) return 32'hFFFF_FFFF;
    return (32'h9E37_79B9 * 32'(w + 1)) ^ (32'h1 << w);
  endfunction

  function automatic logic [31:0] patB(input int w);
    logic [31:0] a = patA(w);
    return {a[15:0], a[31:16]} ^ 32'h0F0F_3C3C;
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at h=%0d v=%0d frame=%0d got %h exp %h",
               tag, what, hm, vm, frameNo, got, exp);
    end
  endtask

  task automatic cpuWrite(input int a, input logic [31:0] d);
    @(negedge cpuClk);
    cpuAddr = 5'(a); cpuWdata = d; cpuWe = 1'b1;
    @(negedge cpuClk);
    cpuWe = 1'b0;
    refMem[a] = d;
  endtask

  task automatic cpuReadChk(input int a);
    @(negedge cpuClk);
    cpuAddr = 5'(a); cpuWe = 1'b0;
    @(posedge cpuClk);
    #1;
    chk(cpuRdata == refMem[a], "R1", "cpu read", cpuRdata, refMem[a]);
  endtask

  // screen model for the pixel whose result appears after this edge
  task automatic expect_at(input int h, input int v, output logic eh,
                           output logic ev, output logic [11:0] er, output string tag);
    int row, col, bl, off;
    logic b, litNow;
    eh = !((h >= HV + HF) && (h < HV + HF + HS));
    ev = !((v >= VV + VF) && (v < VV + VF + VS));
    er = 12'h000;
    if (!(h < HV && v < VV && h >= GL && h < GL + GW && v >= GT && v < GT + GH)) begin
      tag = "R4";
    end else begin
      row = (v - GT) / BH; bl = (v - GT) % BH;
      col = (h - GL) / CW; off = (h - GL) % CW;
      if (!(bl >= MT && bl < MT + MH)) begin
        tag = "R8";
      end else begin
        b = refMem[row][col];
        litNow = (off < (b ? DASH : DOT));
        er = litNow ? 12'hFFF : 12'h000;
        if (frameNo > 0)  tag = "R11";
        else if (b)       tag = litNow ? "R5/R7/R9" : "R5/R7";
        else              tag = litNow ? "R5/R6/R9" : "R5/R6";
      end
    end
  endtask

  task automatic runCompare(input int nCycles);
    logic eh, ev;
    logic [11:0] er;
    string tag;
    for (int i = 0; i < nCycles; i++) begin
      @(negedge pixClk);
      expect_at(hm, vm, eh, ev, er, tag);
      if (i == 0) begin
        chk(hSyncN == eh, "R10", "first hsync", 32'(hSyncN), 32'(eh));
        chk(pixRgb == er, "R10", "first rgb", 32'(pixRgb), 32'(er));
      end
      chk(hSyncN == eh, "R2", "hsync", 32'(hSyncN), 32'(eh));
      chk(vSyncN == ev, "R3", "vsync", 32'(vSyncN), 32'(ev));
      chk(pixRgb == er, tag, "rgb", 32'(pixRgb), 32'(er));
      hm++;
      if (hm == HT) begin
        hm = 0; vm++;
        if (vm == VT) begin vm = 0; frameNo++; end
      end
    end
  endtask

  task automatic rewriteInBlank();
    logic [31:0] oldW;
    wait (frameNo == 0 && vm == VV + 1);
    for (int w = 0; w < 32; w++) if (w != 7) cpuWrite(w, patB(w));
    // R1: read during a write to the same word returns the old word
    oldW = refMem[7];
    @(negedge cpuClk);
    cpuAddr = 5'd7; cpuWdata = patB(7); cpuWe = 1'b1;
    @(posedge cpuClk);
    #1;
    chk(cpuRdata == oldW, "R1", "read during write", cpuRdata, oldW);
    @(negedge cpuClk);
    cpuWe = 1'b0;
    refMem[7] = patB(7);
    cpuReadChk(7);
    cpuReadChk(30);
  endtask

  initial begin : wdog
    repeat (190000) @(posedge pixClk);
    errors++;
    $display("FAIL watchdog expired at h=%0d v=%0d", hm, vm);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : mainSeq
    for (int w = 0; w < 32; w++) cpuWrite(w, patA(w));
    cpuReadChk(0);
    cpuReadChk(13);
    cpuReadChk(31);
    repeat (10) @(negedge pixClk);
    // R10: reset state
    chk(hSyncN == 1'b1, "R10", "reset hsync", 32'(hSyncN), 32'd1);
    chk(vSyncN == 1'b1, "R10", "reset vsync", 32'(vSyncN), 32'd1);
    chk(pixRgb == 12'h0, "R10", "reset rgb", 32'(pixRgb), 32'd0);
    rstN = 1'b1;
    fork
      runCompare(2 * HT * VT);
      rewriteInBlank();
    join
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule